// File: doc/BRIEF.md
# Legacy Audio DMA Block Length Counter

This block is the length engine of a legacy sound-card DMA channel. The sound processor writes a base block length, a current remaining length and a control byte through a byte-wide write port. The wave engine reads the same registers back through a separate read port. Each length register holds the length minus one. A transfer strobe takes one off the current count for every byte, or for every word when the 16-bit format is selected. When the count steps down from zero and wraps, the block emits a one-cycle block-over interrupt, latches it as pending, and reloads the count from the base length. Depending on the auto-continue bit, the channel either keeps running into the next block or falls back to the stop mode.

The three low control bits are held as the state of an eight-state mode machine. The states are MODE_STOP (000), MODE_RUN (001), MODE_SIL_AUDIO (010), MODE_RSV_A (011), MODE_SIL_DMA (100), MODE_PAUSE (101), MODE_RSV_B (110) and MODE_DIRECT (111). The machine has two transitions. A control write moves it from any state to the state whose code is written. A block expiry with auto-continue clear moves it from any state to MODE_STOP. If both happen in the same cycle, the control write wins. The machine's outputs tell the rest of the channel whether counting is enabled, whether it is paused, whether the audio is muted, whether direct play is active, and whether a reserved code was written. The four upper control bits are brought out directly as format outputs.

Top module: `legacy_dma_blkcnt`

## Requirements
- R1: After reset, reads at addresses 0 to 3 return FFh, 07h, FFh and 07h (current and base lengths 07FFh). Address 4 (control) and address 5 (status, bit 0 = interrupt pending) read 00h. blk_irq, irq_pend and chan_counting are 0.
- R2: Address 0 holds the current-count low byte, address 1 its high byte, address 2 the base-length low byte and address 3 its high byte. A write to one of these addresses changes only that byte, and the new value reads back from the next cycle on.
- R3: A write to address 4 stores the control byte, which reads back unchanged. Bit 7 drives fmt_wide, bit 6 fmt_stereo, bit 5 fmt_signed, bit 4 dir_capture, and bit 3 selects auto-continue.
- R4: The mode in control bits 2..0 is decoded as follows. chan_counting is 1 for 001, 100 and 111. chan_paused is 1 for 101. audio_muted is 1 for 010 and 100. direct_play is 1 for 111. mode_reserved is 1 for 011 and 110. Every other decode output is 0.
- R5: Each xfer_stb cycle decrements the current count by exactly one while chan_counting is 1. In every other mode, and in any cycle without a strobe, the count holds.
- R6: A counted strobe with the current count at 0000h reloads the count from the base length. blk_irq goes high for exactly the next cycle, and irq_pend is set.
- R7: On that expiry the mode becomes 000 when control bit 3 is 0. The mode is kept when bit 3 is 1.
- R8: A write of any value to address 5 clears irq_pend. If an expiry falls in the same cycle, irq_pend stays set.
- R9: A write to a current-count byte in the same cycle as a counted strobe takes the written byte. It suppresses both the decrement and the expiry in that cycle, and leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe from the sound processor |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address from the wave engine |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| xfer_stb | input | 1 | One byte or word transferred |
| blk_irq | output | 1 | One-cycle block-over interrupt |
| irq_pend | output | 1 | Latched block-over status |
| chan_counting | output | 1 | Mode allows the count to advance |
| chan_paused | output | 1 | Pause mode |
| audio_muted | output | 1 | Silent audio or silent DMA mode |
| direct_play | output | 1 | Direct-mode play |
| mode_reserved | output | 1 | Reserved mode code written |
| fmt_wide | output | 1 | 16-bit samples; count is in words |
| fmt_stereo | output | 1 | Stereo samples |
| fmt_signed | output | 1 | Signed samples |
| dir_capture | output | 1 | Recording rather than playback |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a block expiry meets a software acknowledge of the pending bit. The bench raises the strobe at count zero in the same cycle as a write to address 5, and requires irq_pend to stay set and blk_irq to pulse. In the second, a counted strobe meets a software write to a current-count byte. The bench drives both together, once at a nonzero count and once at zero. It requires the written byte to land, the other byte to stay as it was, and no interrupt to pulse.

// File: rtl/blkcnt_pkg.sv
package blkcnt_pkg;

    typedef enum logic [2:0] {
        MODE_STOP      = 3'b000,
        MODE_RUN       = 3'b001,
        MODE_SIL_AUDIO = 3'b010,
        MODE_RSV_A     = 3'b011,
        MODE_SIL_DMA   = 3'b100,
        MODE_PAUSE     = 3'b101,
        MODE_RSV_B     = 3'b110,
        MODE_DIRECT    = 3'b111
    } chan_mode_e;

endpackage

// File: rtl/blkcnt_mode_fsm.sv
module blkcnt_mode_fsm
    import blkcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       wrap,
    input  logic       auto_cont,
    output chan_mode_e mode_q,
    output logic       counting,
    output logic       paused,
    output logic       muted,
    output logic       direct,
    output logic       reserved
);

    chan_mode_e mode_d;

    // next-state: a software write wins over the expiry stop
    always_comb begin
        mode_d = mode_q;
        if (mode_wr)
            mode_d = chan_mode_e'(mode_wdata);
        else if (wrap && !auto_cont)
            mode_d = MODE_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_STOP;
        else
            mode_q <= mode_d;
    end

    always_comb begin
        counting = 1'b0;
        paused   = 1'b0;
        muted    = 1'b0;
        direct   = 1'b0;
        reserved = 1'b0;
        unique case (mode_q)
            MODE_STOP:      ;
            MODE_RUN:       counting = 1'b1;
            MODE_SIL_AUDIO: muted    = 1'b1;
            MODE_RSV_A:     reserved = 1'b1;
            MODE_SIL_DMA: begin
                counting = 1'b1;
                muted    = 1'b1;
            end
            MODE_PAUSE:     paused   = 1'b1;
            MODE_RSV_B:     reserved = 1'b1;
            MODE_DIRECT: begin
                counting = 1'b1;
                direct   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/blkcnt_len_ctr.sv
module blkcnt_len_ctr #(
    parameter int                      NBYTES  = 2,
    parameter logic [8*NBYTES-1:0]     RST_LEN = 'h07FF,
    localparam int                     W       = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] cur_be,
    input  logic [NBYTES-1:0] base_be,
    input  logic [7:0]        wdata,
    input  logic              step,
    output logic [W-1:0]      cur_q,
    output logic [W-1:0]      base_q,
    output logic              wrap
);

    logic         cur_wr_any;
    logic [W-1:0] cur_next;

    assign cur_wr_any = |cur_be;
    // expiry: counted step from zero, unless software rewrites the count
    assign wrap       = step && !cur_wr_any && (cur_q == '0);
    assign cur_next   = wrap ? base_q : (cur_q - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= RST_LEN;
            base_q <= RST_LEN;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (cur_be[i])
                    cur_q[8*i +: 8] <= wdata;
                else if (!cur_wr_any && step)
                    cur_q[8*i +: 8] <= cur_next[8*i +: 8];
                if (base_be[i])
                    base_q[8*i +: 8] <= wdata;
            end
        end
    end

endmodule

// File: rtl/blkcnt_irq.sv
module blkcnt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ack,
    output logic blk_irq,
    output logic irq_pend
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_irq  <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            blk_irq <= wrap;
            if (wrap)
                irq_pend <= 1'b1;
            else if (ack)
                irq_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/legacy_dma_blkcnt.sv
module legacy_dma_blkcnt
    import blkcnt_pkg::*;
#(
    parameter int                  NBYTES  = 2,
    parameter logic [8*NBYTES-1:0] RST_LEN = 'h07FF,
    localparam int                 ADDR_W  = $clog2(2*NBYTES + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              xfer_stb,
    output logic              blk_irq,
    output logic              irq_pend,
    output logic              chan_counting,
    output logic              chan_paused,
    output logic              audio_muted,
    output logic              direct_play,
    output logic              mode_reserved,
    output logic              fmt_wide,
    output logic              fmt_stereo,
    output logic              fmt_signed,
    output logic              dir_capture
);

    localparam int W         = 8 * NBYTES;
    localparam int CTRL_ADDR = 2 * NBYTES;
    localparam int STAT_ADDR = 2 * NBYTES + 1;

    logic [NBYTES-1:0] cur_be;
    logic [NBYTES-1:0] base_be;
    logic              ctrl_wr;
    logic              ack;
    logic              step;
    logic              wrap;
    logic              cur_wr_any;
    logic [W-1:0]      cur_q;
    logic [W-1:0]      base_q;
    logic [4:0]        fmt_q;
    chan_mode_e        mode_q;

    for (genvar i = 0; i < NBYTES; i++) begin : g_dec
        assign cur_be[i]  = wr_en && (wr_addr == ADDR_W'(i));
        assign base_be[i] = wr_en && (wr_addr == ADDR_W'(NBYTES + i));
    end

    assign ctrl_wr    = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign ack        = wr_en && (wr_addr == ADDR_W'(STAT_ADDR));
    assign cur_wr_any = |cur_be;
    assign step       = xfer_stb && chan_counting;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fmt_q <= '0;
        else if (ctrl_wr)
            fmt_q <= wr_data[7:3];
    end

    assign fmt_wide    = fmt_q[4];
    assign fmt_stereo  = fmt_q[3];
    assign fmt_signed  = fmt_q[2];
    assign dir_capture = fmt_q[1];

    blkcnt_len_ctr #(.NBYTES(NBYTES), .RST_LEN(RST_LEN)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_be (cur_be),
        .base_be(base_be),
        .wdata  (wr_data),
        .step   (step),
        .cur_q  (cur_q),
        .base_q (base_q),
        .wrap   (wrap)
    );

    blkcnt_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (ctrl_wr),
        .mode_wdata(wr_data[2:0]),
        .wrap      (wrap),
        .auto_cont (fmt_q[0]),
        .mode_q    (mode_q),
        .counting  (chan_counting),
        .paused    (chan_paused),
        .muted     (audio_muted),
        .direct    (direct_play),
        .reserved  (mode_reserved)
    );

    blkcnt_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ack     (ack),
        .blk_irq (blk_irq),
        .irq_pend(irq_pend)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_addr == ADDR_W'(i))
                rd_data = cur_q[8*i +: 8];
            if (rd_addr == ADDR_W'(NBYTES + i))
                rd_data = base_q[8*i +: 8];
        end
        if (rd_addr == ADDR_W'(CTRL_ADDR))
            rd_data = {fmt_q, mode_q};
        if (rd_addr == ADDR_W'(STAT_ADDR))
            rd_data = {7'b0, irq_pend};
    end

endmodule

// File: rtl/blkcnt_chk.sv
module blkcnt_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         xfer_stb,
    input logic         cur_wr,
    input logic         ctrl_wr,
    input logic         auto_cont,
    input logic         counting,
    input logic         paused,
    input logic         direct,
    input logic         reserved,
    input logic [2:0]   mode,
    input logic [W-1:0] cur_q,
    input logic [W-1:0] base_q,
    input logic         blk_irq,
    input logic         irq_pend
);

    // R6
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_irq |-> (cur_q == $past(base_q)));

    // R8
    pend_follows_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_irq |-> irq_pend);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!xfer_stb && !cur_wr) |-> (cur_q == $past(cur_q)));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_stb && counting && !cur_wr && (cur_q != '0))
        |-> (cur_q == W'($past(cur_q) - 1'b1)));

    // R7
    stop_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_irq && $past(!ctrl_wr && !auto_cont)) |-> (mode == 3'b000));

    // R4
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({paused, direct, reserved}));

endmodule

bind legacy_dma_blkcnt blkcnt_chk #(.W(8*NBYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_stb (xfer_stb),
    .cur_wr   (cur_wr_any),
    .ctrl_wr  (ctrl_wr),
    .auto_cont(fmt_q[0]),
    .counting (chan_counting),
    .paused   (chan_paused),
    .direct   (direct_play),
    .reserved (mode_reserved),
    .mode     (mode_q),
    .cur_q    (cur_q),
    .base_q   (base_q),
    .blk_irq  (blk_irq),
    .irq_pend (irq_pend)
);

// File: tb/legacy_dma_blkcnt_test.sv
`timescale 1ns/1ps
module legacy_dma_blkcnt_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       xfer_stb = 1'b0;
    logic       blk_irq, irq_pend, chan_counting, chan_paused, audio_muted;
    logic       direct_play, mode_reserved, fmt_wide, fmt_stereo, fmt_signed, dir_capture;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    legacy_dma_blkcnt uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .xfer_stb(xfer_stb),
        .blk_irq(blk_irq), .irq_pend(irq_pend), .chan_counting(chan_counting),
        .chan_paused(chan_paused), .audio_muted(audio_muted), .direct_play(direct_play),
        .mode_reserved(mode_reserved), .fmt_wide(fmt_wide), .fmt_stereo(fmt_stereo),
        .fmt_signed(fmt_signed), .dir_capture(dir_capture)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stb();
        @(negedge clk);
        xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
    endtask

    task automatic set_cur(input logic [15:0] v);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
    endtask

    task automatic set_base(input logic [15:0] v);
        wr(3'd2, v[7:0]);
        wr(3'd3, v[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1 cur lo", d, 8'hFF);
        rd(3'd1, d); chk("R1 cur hi", d, 8'h07);
        rd(3'd2, d); chk("R1 base lo", d, 8'hFF);
        rd(3'd3, d); chk("R1 base hi", d, 8'h07);
        rd(3'd4, d); chk("R1 ctrl", d, 8'h00);
        rd(3'd5, d); chk("R1 status", d, 8'h00);
        chk("R1 outputs", {blk_irq, irq_pend, chan_counting}, 3'b000);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(3'd0, 8'h34);
        rd16(3'd0, v); chk("R2 cur lo only", v, 16'h0734);
        wr(3'd1, 8'h12);
        wr(3'd2, 8'h78);
        wr(3'd3, 8'h56);
        rd16(3'd0, v); chk("R2 cur", v, 16'h1234);
        rd16(3'd2, v); chk("R2 base", v, 16'h5678);
    endtask

    task automatic t_ctrl();
        logic [7:0] d, c;
        for (int m = 0; m < 8; m++) begin
            c = {((m % 2) == 0) ? 5'b10100 : 5'b01010, 3'(m)};
            wr(3'd4, c);
            rd(3'd4, d); chk("R3 ctrl readback", d, c);
            chk("R3 format bits", {fmt_wide, fmt_stereo, fmt_signed, dir_capture}, c[7:4]);
            chk("R4 decode",
                {chan_counting, chan_paused, audio_muted, direct_play, mode_reserved},
                {(m == 1 || m == 4 || m == 7), (m == 5), (m == 2 || m == 4),
                 (m == 7), (m == 3 || m == 6)});
        end
    endtask

    task automatic t_modes();
        logic [15:0] v;
        for (int m = 0; m < 8; m++) begin
            wr(3'd4, {5'b00001, 3'(m)});
            set_cur(16'h0100);
            stb();
            stb();
            repeat (3) @(negedge clk);
            rd16(3'd0, v);
            chk("R5 count per mode", v,
                (m == 1 || m == 4 || m == 7) ? 16'h00FE : 16'h0100);
        end
    endtask

    task automatic t_wrap_stop();
        logic [15:0] v;
        logic [7:0] d;
        set_base(16'h0002);
        set_cur(16'h0001);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h01);
        stb();
        rd16(3'd0, v); chk("R5 step to zero", v, 16'h0000);
        chk("R6 no irq before wrap", blk_irq, 1'b0);
        stb();
        chk("R6 irq pulse high", blk_irq, 1'b1);
        rd16(3'd0, v); chk("R6 reload", v, 16'h0002);
        chk("R6 pending set", irq_pend, 1'b1);
        rd(3'd4, d); chk("R7 stop mode", d, 8'h00);
        @(negedge clk);
        chk("R6 irq one cycle", blk_irq, 1'b0);
        stb();
        rd16(3'd0, v); chk("R7 stopped holds", v, 16'h0002);
    endtask

    task automatic t_wrap_cont();
        logic [15:0] v;
        logic [7:0] d;
        set_base(16'h0005);
        set_cur(16'h0000);
        wr(3'd4, 8'h0C);
        stb();
        chk("R6 cont irq", blk_irq, 1'b1);
        rd16(3'd0, v); chk("R6 cont reload", v, 16'h0005);
        rd(3'd4, d); chk("R7 mode kept", d, 8'h0C);
        stb();
        rd16(3'd0, v); chk("R7 next block counts", v, 16'h0004);
    endtask

    task automatic t_ack();
        logic [7:0] d;
        wr(3'd5, 8'hA5);
        rd(3'd5, d); chk("R8 ack clears", d, 8'h00);
        set_cur(16'h0000);
        wr(3'd4, 8'h09);
        @(negedge clk);
        xfer_stb = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h01;
        @(negedge clk);
        xfer_stb = 1'b0; wr_en = 1'b0;
        chk("R8 race irq", blk_irq, 1'b1);
        chk("R8 set beats clear", irq_pend, 1'b1);
        wr(3'd5, 8'h00);
        chk("R8 later ack", irq_pend, 1'b0);
    endtask

    task automatic t_wr_race();
        logic [15:0] v;
        set_cur(16'h0010);
        wr(3'd4, 8'h09);
        @(negedge clk);
        xfer_stb = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h55;
        @(negedge clk);
        xfer_stb = 1'b0; wr_en = 1'b0;
        rd16(3'd0, v); chk("R9 write wins", v, 16'h0055);
        set_cur(16'h0000);
        @(negedge clk);
        xfer_stb = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h03;
        @(negedge clk);
        xfer_stb = 1'b0; wr_en = 1'b0;
        chk("R9 no expiry", blk_irq, 1'b0);
        rd16(3'd0, v); chk("R9 hi written", v, 16'h0300);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_ctrl();
        t_modes();
        t_wrap_stop();
        t_wrap_cont();
        t_ack();
        t_wr_race();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule